// File: doc/BRIEF.md
# I2C Write-Only Slave Receiver with Host-Paced Byte Flow

This block is an I2C-bus slave that only accepts write transfers. It samples the SCL and SDA lines on a fast system clock and finds START and STOP conditions. It compares the first byte after a START with its own 7-bit address and a write direction bit. After that it shifts in data bytes until the master ends the transfer with STOP.

Each accepted byte raises an interrupt request, including the address byte. The block then stretches the clock by holding SCL low. The host reads the byte and the status, then programs the acknowledge response. Its write to the data register releases the bus. The acknowledge response can be set per byte, so software can refuse the final byte of a transfer. The block has no fixed byte count: the master decides when to stop.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o` and `irq_o` are all 0, so both bus lines are released.
- R2: A START (SDA falling while SCL is high) begins address reception from any state. A START issued without a preceding STOP (a repeated start) restarts address reception, and the new address byte is handled like a first one.
- R3: When the first byte after a START carries `own_addr_i` in its upper seven bits and a 0 (write) in bit 0, the block sets `irq_o` and `addr_evt_o`, reports `trx_o` = 0, and holds SCL low (`scl_oe_o` = 1).
- R4: While SCL is held low after an event, a write with `reg_sel_i` = 0 (data register) releases SCL two clock cycles later. Writes with `reg_sel_i` = 1 (control) do not release it, and neither does the passage of time.
- R5: After the address event is released, the block pulls SDA low (ACK) for the following acknowledge slot.
- R6: Data bits are taken on SCL rising edges, most significant bit first. At the data-byte event the whole byte appears on `rx_data_o`, with `addr_evt_o` = 0.
- R7: Control write bit 0 selects the response to a data byte: 0 pulls SDA low (ACK), 1 leaves SDA released (NACK). The value held when the data register is written is the one used.
- R8: `sda_oe_o` changes only while the synchronised SCL is low.
- R9: `irq_o` is cleared by a pulse on `irq_ack_i`, or by a control write with bit 1 set. A new event in the same cycle takes priority over the clear.
- R10: If the address differs, or the direction bit is 1, the block gives no ACK, raises no request and does not stretch SCL. It ignores the bus until the next START or STOP. `trx_o` still records the direction bit when the address matched.
- R11: A STOP (SDA rising while SCL is high) ends reception after any number of bytes. Clock pulses that arrive afterwards without a START are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK) |
| own_addr_i | input | 7 | Slave address of this block |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 2 | 0 = data register, 1 = control register |
| reg_wdata_i | input | 2 | Control write: bit 0 NACK select, bit 1 request clear; ignored for data writes |
| irq_ack_i | input | 1 | Interrupt acceptance pulse, clears the request |
| irq_o | output | 1 | Interrupt request flag |
| rx_data_o | output | 8 | Last received data byte |
| trx_o | output | 1 | Direction bit of the last matching address (0 = slave receive) |
| addr_evt_o | output | 1 | 1 when the pending event is the address byte |

## Verification
The properties assume that each SCL high and low phase lasts far longer than the synchroniser and edge-detector delay. This assumption underlies the check that SDA only moves while SCL is low. It also underlies the check that clock stretching ends only on a data-register write. The master model keeps every half bit at twenty system clocks and changes SDA only with SCL low, except when it makes START and STOP. It waits for the SCL line to go high before it times the high phase. The host model never writes the data register outside a stretch, and it never writes two registers in one cycle.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_HOLD, ST_REL, ST_ACK, ST_SKIP
  } srx_state_e;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam int CTRL_W       = 2;
  localparam int CTRL_NACK    = 0;
  localparam int CTRL_IRQ_CLR = 1;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= '1;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '1;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edges only count as conditions while SCL stays high
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
  import i2c_srx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              release_i,
  input  logic              nack_i,
  output logic              scl_hold_o,
  output logic              sda_drv_o,
  output logic              evt_o,
  output logic              addr_evt_o,
  output logic              trx_o,
  output logic [DATA_W-1:0] rx_data_o
);
  srx_state_e        st;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              byte_end, addr_hit, addr_go;

  assign byte_end = scl_fall_i && (cnt == CNT_W'(DATA_W));
  assign addr_hit = (sh[DATA_W-1:1] == own_addr_i);
  assign addr_go  = addr_hit && !sh[0];
  assign evt_o    = !stop_i && !start_i && byte_end &&
                    ((st == ST_ADDR && addr_go) || st == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st         <= ST_IDLE;
      sh         <= '0;
      cnt        <= '0;
      scl_hold_o <= 1'b0;
      sda_drv_o  <= 1'b0;
      addr_evt_o <= 1'b0;
      trx_o      <= 1'b0;
      rx_data_o  <= '0;
    end else if (stop_i) begin
      st         <= ST_IDLE;
      scl_hold_o <= 1'b0;
      sda_drv_o  <= 1'b0;
    end else if (start_i) begin
      st         <= ST_ADDR;
      cnt        <= '0;
      scl_hold_o <= 1'b0;
      sda_drv_o  <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_DATA: begin
          if (scl_rise_i) begin
            sh  <= {sh[DATA_W-2:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (byte_end) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (addr_hit) trx_o <= sh[0];
              if (addr_go) begin
                st         <= ST_HOLD;
                scl_hold_o <= 1'b1;
                addr_evt_o <= 1'b1;
              end else begin
                st <= ST_SKIP;
              end
            end else begin
              rx_data_o  <= sh;
              st         <= ST_HOLD;
              scl_hold_o <= 1'b1;
              addr_evt_o <= 1'b0;
            end
          end
        end
        ST_HOLD: if (release_i) begin
          // address is always acknowledged, data follows the host's choice
          sda_drv_o <= addr_evt_o | ~nack_i;
          st        <= ST_REL;
        end
        ST_REL: begin
          // one cycle of SDA setup before SCL is let go
          scl_hold_o <= 1'b0;
          st         <= ST_ACK;
        end
        ST_ACK: if (scl_fall_i) begin
          sda_drv_o <= 1'b0;
          cnt       <= '0;
          st        <= ST_DATA;
        end
        default: ;
      endcase
    end
endmodule

// File: rtl/i2c_srx_hostif.sv
module i2c_srx_hostif
  import i2c_srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  input  logic              irq_ack_i,
  input  logic              evt_i,
  output logic              nack_o,
  output logic              irq_o,
  output logic              release_o
);
  logic ctrl_wr;

  assign ctrl_wr   = reg_wr_i && (reg_sel_i == SEL_CTRL);
  assign release_o = reg_wr_i && (reg_sel_i == SEL_DATA);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      nack_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (ctrl_wr) nack_o <= reg_wdata_i[CTRL_NACK];
      if (evt_i)
        irq_o <= 1'b1;
      else if (irq_ack_i || (ctrl_wr && reg_wdata_i[CTRL_IRQ_CLR]))
        irq_o <= 1'b0;
    end
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [CTRL_W-1:0] reg_wdata_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              trx_o,
  output logic              addr_evt_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;
  logic evt, rel, nack;

  i2c_srx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i, .rst_ni,
    .d_i({scl_i, sda_i}),
    .q_o({scl_s, sda_s})
  );

  i2c_srx_cond u_cond (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_srx_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c),
    .sda_i(sda_s), .own_addr_i,
    .release_i(rel), .nack_i(nack),
    .scl_hold_o(scl_oe_o), .sda_drv_o(sda_oe_o),
    .evt_o(evt), .addr_evt_o, .trx_o, .rx_data_o
  );

  i2c_srx_hostif u_host (
    .clk_i, .rst_ni,
    .reg_wr_i, .reg_sel_i, .reg_wdata_i, .irq_ack_i,
    .evt_i(evt), .nack_o(nack), .irq_o, .release_o(rel)
  );
endmodule

// File: rtl/i2c_srx_checker.sv
module i2c_srx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic irq_o,
  input logic irq_ack_i,
  input logic evt,
  input logic rel,
  input logic nack,
  input logic addr_evt_o
);
  p_sda_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  p_stretch_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> $past(rel, 2));

  p_irq_on_stretch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> irq_o);

  p_addr_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) && addr_evt_o |-> sda_oe_o);

  p_data_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) && !addr_evt_o |-> sda_oe_o == !$past(nack, 2));

  p_irq_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i && !evt |=> !irq_o);
endmodule

bind i2c_slave_rx i2c_srx_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .irq_o(irq_o), .irq_ack_i(irq_ack_i), .evt(evt),
  .rel(rel), .nack(nack), .addr_evt_o(addr_evt_o)
);

// File: tb/tb_i2c_slave_rx.sv
module tb_i2c_slave_rx;
  localparam int HP = 20;
  localparam logic [6:0] OWN = 7'h5A;

  typedef struct {
    logic       is_addr;
    logic [7:0] data;
    logic       nack;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe_o, sda_oe_o, irq_o, trx_o, addr_evt_o;
  logic [7:0] rx_data_o;
  logic reg_wr_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd0;
  logic [1:0] reg_wdata_i = 2'd0;
  logic irq_ack_i = 1'b0;
  logic scl_line, sda_line;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit clr_by_ack = 1'b0;
  item_t exp_q[$];
  logic [7:0] pay [8];

  always #4 clk = ~clk;

  assign scl_line = m_scl & ~scl_oe_o;
  assign sda_line = m_sda & ~sda_oe_o;

  i2c_slave_rx dut (
    .clk_i(clk), .rst_ni, .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o, .sda_oe_o, .own_addr_i(OWN),
    .reg_wr_i, .reg_sel_i, .reg_wdata_i, .irq_ack_i,
    .irq_o, .rx_data_o, .trx_o, .addr_evt_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- master bus model ----------------
  task automatic hwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; hwait(HP);
    m_scl = 1'b1; while (!scl_line) @(negedge clk); hwait(HP);
    m_sda = 1'b0; hwait(HP);
    m_scl = 1'b0; hwait(HP);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hwait(HP);
    m_scl = 1'b1; while (!scl_line) @(negedge clk); hwait(HP);
    m_sda = 1'b1; hwait(HP);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b; hwait(HP);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    hwait(HP/2);
    r = sda_line;
    hwait(HP/2);
    m_scl = 1'b0; hwait(HP);
  endtask

  task automatic m_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r);
    m_bit(1'b1, ack);
  endtask

  // driver: pushes the expected events, checks acknowledge levels
  task automatic xfer(input logic [6:0] a, input logic rw, input int n,
                      input bit last_nack, input bit do_stop);
    logic ack;
    bit hit;
    item_t it;
    hit = (a == OWN) && !rw;
    if (hit) begin
      it.is_addr = 1'b1; it.data = 8'h00; it.nack = 1'b0;
      exp_q.push_back(it);
    end
    m_start();
    m_byte({a, rw}, ack);
    if (hit) chk(ack == 1'b0, "R5", "address ack", ack, 0);
    else     chk(ack == 1'b1, "R10", "no ack on foreign/read address", ack, 1);
    for (int k = 0; k < n; k++) begin
      bit lst;
      lst = last_nack && (k == n - 1);
      if (hit) begin
        it.is_addr = 1'b0; it.data = pay[k]; it.nack = lst;
        exp_q.push_back(it);
      end
      m_byte(pay[k], ack);
      if (!hit)
        chk(ack == 1'b1, "R10", "data ignored after mismatch", ack, 1);
      else if (lst)
        chk(ack == 1'b1, "R7", "nack on last byte", ack, 1);
      else
        chk(ack == 1'b0, "R7", "ack on data byte", ack, 0);
    end
    if (do_stop) m_stop();
  endtask

  // ---------------- host model / scoreboard monitor ----------------
  task automatic handle_event();
    item_t it;
    logic exp_sda;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R10", "unexpected interrupt", irq_o, 0);
      it.is_addr = addr_evt_o; it.data = 8'h00; it.nack = 1'b1;
    end else begin
      it = exp_q.pop_front();
    end
    chk(scl_oe_o == 1'b1, "R3", "scl stretched at event", scl_oe_o, 1);
    chk(addr_evt_o == it.is_addr, "R3", "event kind", addr_evt_o, it.is_addr);
    if (it.is_addr)
      chk(trx_o == 1'b0, "R3", "receive direction", trx_o, 0);
    else
      chk(rx_data_o == it.data, "R6", "received byte", rx_data_o, it.data);
    // program acknowledge choice, clear the request one of two ways
    reg_wr_i = 1'b1; reg_sel_i = 2'd1;
    reg_wdata_i = {~clr_by_ack, it.nack};
    @(negedge clk);
    reg_wr_i = 1'b0;
    if (clr_by_ack) begin
      irq_ack_i = 1'b1;
      @(negedge clk);
      irq_ack_i = 1'b0;
    end
    chk(irq_o == 1'b0, "R9", "request cleared", irq_o, 0);
    clr_by_ack = ~clr_by_ack;
    hwait(30);
    chk(scl_oe_o == 1'b1 && scl_line == 1'b0, "R4",
        "scl still held before data write", scl_oe_o, 1);
    // dummy data-register write releases the bus
    reg_wr_i = 1'b1; reg_sel_i = 2'd0; reg_wdata_i = 2'b11;
    @(negedge clk);
    reg_wr_i = 1'b0;
    exp_sda = it.is_addr ? 1'b1 : ~it.nack;
    chk(sda_oe_o == exp_sda, it.is_addr ? "R5" : "R7",
        "sda drive set while scl held", sda_oe_o, exp_sda);
    chk(scl_oe_o == 1'b1, "R8", "sda set up before scl release", scl_oe_o, 1);
    @(negedge clk);
    chk(scl_oe_o == 1'b0, "R4", "scl released after data write", scl_oe_o, 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && irq_o) handle_event();
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    hwait(5);
    chk(scl_oe_o == 1'b0, "R1", "scl released in reset", scl_oe_o, 0);
    chk(sda_oe_o == 1'b0, "R1", "sda released in reset", sda_oe_o, 0);
    chk(irq_o == 1'b0, "R1", "no request in reset", irq_o, 0);
    rst_ni = 1'b1;
    hwait(10);

    // plain write: three bytes, last refused
    pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'h0F;
    xfer(OWN, 1'b0, 3, 1'b1, 1'b1);
    hwait(HP);

    // R2: repeated start between two segments
    pay[0] = 8'h81; pay[1] = 8'h7E; pay[2] = 8'h00; pay[3] = 8'hFF;
    xfer(OWN, 1'b0, 4, 1'b0, 1'b0);
    pay[0] = 8'h12; pay[1] = 8'hED;
    xfer(OWN, 1'b0, 2, 1'b1, 1'b1);
    chk(exp_q.size() == 0, "R2", "events after repeated start", exp_q.size(), 0);
    hwait(HP);

    // R10: foreign address, then own address with read direction
    pay[0] = 8'h55;
    xfer(7'h21, 1'b0, 1, 1'b0, 1'b1);
    chk(irq_o == 1'b0 && scl_oe_o == 1'b0, "R10", "idle after mismatch", irq_o, 0);
    xfer(OWN, 1'b1, 1, 1'b0, 1'b1);
    chk(trx_o == 1'b1, "R10", "direction bit recorded", trx_o, 1);
    hwait(HP);

    // R11: clocks after STOP without START are ignored
    m_byte(8'hB4, ack);
    chk(ack == 1'b1, "R11", "no ack after stop", ack, 1);
    chk(irq_o == 1'b0 && scl_oe_o == 1'b0, "R11", "no event after stop", irq_o, 0);

    // single-byte transfer, that byte is the last one
    pay[0] = 8'hC3;
    xfer(OWN, 1'b0, 1, 1'b1, 1'b1);
    hwait(HP);
    chk(exp_q.size() == 0, "R11", "all expected events seen", exp_q.size(), 0);
    chk(scl_oe_o == 1'b0 && sda_oe_o == 1'b0, "R11", "bus free after stop",
        {scl_oe_o, sda_oe_o}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule